// File: doc/BRIEF.md
# Maskable Interrupt Status Register

This block keeps the eight-bit interrupt status byte and the eight-bit enable mask of a network controller, and drives one level-sensitive interrupt line toward the host. Event logic elsewhere in the controller sends single-cycle pulses that set status bits. These pulses cover receive complete, buffer allocation complete, overrun, early receive, link-layer and management events. Two bits follow queue occupancy: tx-empty and tx-done. Each is forced to one for as long as its queue condition holds.

The host clears bits by writing an acknowledge byte. Only some bits can be cleared this way. The receive bit, the allocate bit and the link-layer bit ignore an acknowledge. The receive bit follows the receive queue when an entry is removed. The allocate bit is cleared when a new allocation request starts. Acknowledging the tx-done bit also sends a one-cycle pop request to the transmit-completion queue. The interrupt line is registered, and it reflects any bit that is set in both the status and the mask.

Top module: `irq_status_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), `status` is 0x04, `mask` is 0x00 and `irq` is 0.
- R2: Bit positions are: 0 receive, 1 tx-done, 2 tx-empty, 3 allocate, 4 overrun, 5 link-layer, 6 early receive, 7 management. A pulse on `ev_set[i]` sets `status[i]` at the next edge, and the bit stays set.
- R3: An acknowledge write (`ack_we`) clears, at the next edge, only those bits of `ack_data` that are also in 0xD6 (bits 7, 6, 4, 2, 1). Bits 0, 3 and 5 are left unchanged by any acknowledge.
- R4: `status[2]` is set at every edge where `txq_empty` is high. `status[1]` is set at every edge where `tdq_nonempty` is high. While the condition holds, an acknowledge cannot clear the bit.
- R5: `tdq_pop` is high, in the same cycle, exactly when `ack_we` is high with `ack_data[1]` set.
- R6: A write with `mask_we` loads `mask_data` into `mask` at the next edge.
- R7: `irq` is a register. After each edge it equals the OR of (`status` & `mask`) as they stood before that edge, so it lags a status or mask change by one cycle.
- R8: When `rx_pop` is high, `status[0]` is set at the next edge if `rx_more` is high, and cleared if `rx_more` is low.
- R9: `alloc_req` clears `status[3]` at the next edge.
- R10: When a set source and a clear source hit the same bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_set | input | 8 | Per-bit event set pulses |
| txq_empty | input | 1 | Transmit queue holds no entries |
| tdq_nonempty | input | 1 | Transmit-completion queue holds entries |
| rx_pop | input | 1 | An entry is being removed from the receive queue |
| rx_more | input | 1 | Entries remain in the receive queue after the removal |
| alloc_req | input | 1 | A new allocation request starts |
| ack_we | input | 1 | Acknowledge write strobe |
| ack_data | input | 8 | Acknowledge byte |
| mask_we | input | 1 | Mask write strobe |
| mask_data | input | 8 | Mask byte |
| status | output | 8 | Readable status byte |
| mask | output | 8 | Readable mask byte |
| irq | output | 1 | Level interrupt, registered |
| tdq_pop | output | 1 | Pop request to the transmit-completion queue |

## Verification
The bench acknowledges all eight bits at once. A design that applied the full byte instead of the 0xD6 filter would wipe the receive, allocate and link-layer bits. It acknowledges tx-empty and tx-done while their queue conditions still hold and again after they drop, which catches a design that lets the clear win or that makes those bits non-sticky. It also fires a set and an acknowledge on the same bit in one cycle, and it exercises receive removal both with and without remaining entries. Separately, it times `irq` one cycle behind each mask and status change, so that an unregistered or doubly registered interrupt is reported.

// File: rtl/isr_pkg.sv
// Shared constants for the interrupt status block.
// Assumes an eight-bit status and mask byte with fixed bit roles.
package isr_pkg;
    localparam int STAT_W       = 8;
    localparam int BIT_RX       = 0;
    localparam int BIT_TXDONE   = 1;
    localparam int BIT_TXEMPTY  = 2;
    localparam int BIT_ALLOC    = 3;
    localparam int BIT_OVERRUN  = 4;
    localparam int BIT_LINK     = 5;
    localparam int BIT_EARLY_RX = 6;
    localparam int BIT_MGMT     = 7;
    localparam logic [STAT_W-1:0] ACK_CLR_MASK = 8'hD6;
    localparam logic [STAT_W-1:0] STAT_RESET   = 8'h04;
    localparam logic [STAT_W-1:0] MASK_RESET   = 8'h00;
endpackage

// File: rtl/isr_event_merge.sv
// Builds per-bit set and clear vectors from events, queue levels and
// host acknowledge writes. Purely combinational.
// Assumes single-cycle pulses on ev_set, rx_pop, alloc_req and ack_we.
module isr_event_merge
    import isr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] ev_set,
    input  logic              txq_empty,
    input  logic              tdq_nonempty,
    input  logic              rx_pop,
    input  logic              rx_more,
    input  logic              alloc_req,
    input  logic              ack_we,
    input  logic [STAT_W-1:0] ack_data,
    output logic [STAT_W-1:0] set_vec,
    output logic [STAT_W-1:0] clr_vec,
    output logic              tdq_pop
);
    // Set sources: event pulses, forced queue bits, receive pop with remaining entries.
    always_comb begin
        set_vec               = ev_set;
        set_vec[BIT_TXEMPTY]  = ev_set[BIT_TXEMPTY] | txq_empty;
        set_vec[BIT_TXDONE]   = ev_set[BIT_TXDONE]  | tdq_nonempty;
        set_vec[BIT_RX]       = ev_set[BIT_RX]      | (rx_pop & rx_more);
    end

    // Clear sources: filtered acknowledge, receive queue drained, new allocation.
    always_comb begin
        clr_vec            = ack_we ? (ack_data & ACK_CLR_MASK) : '0;
        clr_vec[BIT_RX]    = rx_pop & ~rx_more;
        clr_vec[BIT_ALLOC] = alloc_req;
    end

    // Pop request whenever the tx-done bit is acknowledged.
    always_comb tdq_pop = ack_we & ack_data[BIT_TXDONE];

    AST_ACK_NEVER_CLEARS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        ack_we |-> ((clr_vec & ~ACK_CLR_MASK & ~(8'h01 << BIT_RX) & ~(8'h01 << BIT_ALLOC)) == '0)); // R3
endmodule

// File: rtl/isr_status_reg.sv
// Sticky status byte. Each bit is set by its set line, cleared by its
// clear line, and the set wins when both are high in one cycle.
// Assumes set_vec and clr_vec are settled before the clock edge.
module isr_status_reg
    import isr_pkg::*;
#(
    parameter int                W         = STAT_W,
    parameter logic [W-1:0]      RESET_VAL = STAT_RESET
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] status
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // One status flop with set priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)           status[i] <= RESET_VAL[i];
            else if (set_vec[i])  status[i] <= 1'b1;
            else if (clr_vec[i])  status[i] <= 1'b0;
        end
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((status & $past(set_vec)) == $past(set_vec))); // R10
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_vec & ~set_vec) != '0) |=> ((status & $past(clr_vec & ~set_vec)) == '0)); // R3
    AST_UNTOUCHED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(set_vec | clr_vec)) == ($past(status) & ~$past(set_vec | clr_vec)))); // R2
endmodule

// File: rtl/isr_mask_reg.sv
// Host-written interrupt enable byte.
// Assumes mask_we is a single-cycle write strobe.
module isr_mask_reg
    import isr_pkg::*;
#(
    parameter int           W         = STAT_W,
    parameter logic [W-1:0] RESET_VAL = MASK_RESET
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mask_we,
    input  logic [W-1:0] mask_data,
    output logic [W-1:0] mask
);
    // Load the mask on write, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= RESET_VAL;
        else if (mask_we) mask <= mask_data;
    end

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (mask == $past(mask_data))); // R6
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we |=> $stable(mask)); // R6
endmodule

// File: rtl/isr_irq_gen.sv
// Registered interrupt line: high when any enabled status bit is set.
// Assumes status and mask come straight from flops.
module isr_irq_gen
    import isr_pkg::*;
#(
    parameter int W = STAT_W
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] status,
    input  logic [W-1:0] mask,
    output logic         irq
);
    // Register the OR of enabled pending bits.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(status & mask);
    end

    AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == (|($past(status) & $past(mask))))); // R7
endmodule

// File: rtl/irq_status_ctrl.sv
// Top of the maskable interrupt status block: merges event, queue and
// acknowledge inputs, keeps status and mask, drives a registered irq and
// a pop request to the transmit-completion queue.
// Assumes all inputs are synchronous to clk.
module irq_status_ctrl
    import isr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] ev_set,
    input  logic              txq_empty,
    input  logic              tdq_nonempty,
    input  logic              rx_pop,
    input  logic              rx_more,
    input  logic              alloc_req,
    input  logic              ack_we,
    input  logic [STAT_W-1:0] ack_data,
    input  logic              mask_we,
    input  logic [STAT_W-1:0] mask_data,
    output logic [STAT_W-1:0] status,
    output logic [STAT_W-1:0] mask,
    output logic              irq,
    output logic              tdq_pop
);
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] clr_vec;

    isr_event_merge u_merge (
        .clk(clk), .rst_n(rst_n), .ev_set(ev_set), .txq_empty(txq_empty),
        .tdq_nonempty(tdq_nonempty), .rx_pop(rx_pop), .rx_more(rx_more),
        .alloc_req(alloc_req), .ack_we(ack_we), .ack_data(ack_data),
        .set_vec(set_vec), .clr_vec(clr_vec), .tdq_pop(tdq_pop)
    );

    isr_status_reg #(.W(STAT_W), .RESET_VAL(STAT_RESET)) u_status (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
        .status(status)
    );

    isr_mask_reg #(.W(STAT_W), .RESET_VAL(MASK_RESET)) u_mask (
        .clk(clk), .rst_n(rst_n), .mask_we(mask_we), .mask_data(mask_data),
        .mask(mask)
    );

    isr_irq_gen #(.W(STAT_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .status(status), .mask(mask), .irq(irq)
    );

    AST_TXEMPTY_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        txq_empty |=> status[BIT_TXEMPTY]); // R4
    AST_TXDONE_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        tdq_nonempty |=> status[BIT_TXDONE]); // R4
    AST_RX_IGNORES_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_we && !ev_set[BIT_RX] && !rx_pop) |=> (status[BIT_RX] == $past(status[BIT_RX]))); // R3
    AST_POP_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        tdq_pop |-> (ack_we && ack_data[BIT_TXDONE])); // R5
    AST_RX_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && !rx_more && !ev_set[BIT_RX]) |=> !status[BIT_RX]); // R8
    AST_ALLOC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && !ev_set[BIT_ALLOC]) |=> !status[BIT_ALLOC]); // R9
endmodule

// File: tb/irq_status_ctrl_bench.sv
module irq_status_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ev_set = '0;
    logic       txq_empty = 1'b1;
    logic       tdq_nonempty = 1'b0;
    logic       rx_pop = 1'b0;
    logic       rx_more = 1'b0;
    logic       alloc_req = 1'b0;
    logic       ack_we = 1'b0;
    logic [7:0] ack_data = '0;
    logic       mask_we = 1'b0;
    logic [7:0] mask_data = '0;
    logic [7:0] status;
    logic [7:0] mask;
    logic       irq;
    logic       tdq_pop;

    int checks = 0;
    int fails  = 0;

    logic [7:0] m_stat = 8'h04;
    logic [7:0] m_mask = 8'h00;
    logic [16:0] q_exp[$];
    string       q_tag[$];
    bit          done = 0;

    always #5 clk = ~clk;

    irq_status_ctrl u_irq_status_ctrl (
        .clk(clk), .rst_n(rst_n), .ev_set(ev_set), .txq_empty(txq_empty),
        .tdq_nonempty(tdq_nonempty), .rx_pop(rx_pop), .rx_more(rx_more),
        .alloc_req(alloc_req), .ack_we(ack_we), .ack_data(ack_data),
        .mask_we(mask_we), .mask_data(mask_data), .status(status),
        .mask(mask), .irq(irq), .tdq_pop(tdq_pop)
    );

    task automatic check(input bit ok, input string tag, input logic [16:0] act, input logic [16:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus, check pop, push expected result.
    task automatic step(input logic [7:0] ev, input logic txe, input logic tdn,
                        input logic rp, input logic rm, input logic al,
                        input logic aw, input logic [7:0] ad,
                        input logic mw, input logic [7:0] md, input string tag);
        logic [7:0] setv, clrv, ns, nm;
        logic       ni;
        @(negedge clk);
        ev_set = ev; txq_empty = txe; tdq_nonempty = tdn; rx_pop = rp;
        rx_more = rm; alloc_req = al; ack_we = aw; ack_data = ad;
        mask_we = mw; mask_data = md;
        #1;
        check(tdq_pop == (aw & ad[1]), "R5", {16'h0, tdq_pop}, {16'h0, aw & ad[1]});
        setv = ev | (txe ? 8'h04 : 8'h00) | (tdn ? 8'h02 : 8'h00) | ((rp & rm) ? 8'h01 : 8'h00);
        clrv = (aw ? (ad & 8'hD6) : 8'h00) | ((rp & ~rm) ? 8'h01 : 8'h00) | (al ? 8'h08 : 8'h00);
        ns = (m_stat & ~clrv) | setv;
        nm = mw ? md : m_mask;
        ni = |(m_stat & m_mask);
        @(posedge clk);
        q_exp.push_back({ns, nm, ni});
        q_tag.push_back(tag);
        m_stat = ns; m_mask = nm;
    endtask

    // Monitor: compare outputs after each edge against the queue head.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q_exp.size() > 0) begin
                logic [16:0] e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                check({status, mask, irq} == e, t, {status, mask, irq}, e);
            end
        end
    end

    initial begin
        #100000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check({status, mask, irq} == {8'h04, 8'h00, 1'b0}, "R1", {status, mask, irq}, {8'h04, 8'h00, 1'b0});
        @(negedge clk);
        rst_n = 1'b1;
        //    ev     txe  tdn  rp   rm   al   aw   ad     mw   md
        step(8'h01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, "R2");
        step(8'hF0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, "R2");
        step(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 8'hFF, "R6");
        step(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, "R7");
        step(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 1'b0, 8'h00, "R3");
        step(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, "R3");
        step(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, "R4");
        step(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h04, 1'b0, 8'h00, "R4");
        step(8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, "R4");
        step(8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h02, 1'b0, 8'h00, "R4");
        step(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h06, 1'b0, 8'h00, "R3");
        step(8'h08, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, "R2");
        step(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h29, 1'b0, 8'h00, "R3");
        step(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, "R9");
        step(8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, "R8");
        step(8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, "R8");
        step(8'h10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h10, 1'b0, 8'h00, "R10");
        step(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 8'h00, "R7");
        step(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, "R7");
        step(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFD, 1'b1, 8'h01, "R5");
        step(8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, "R7");
        step(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, "R7");
        @(negedge clk);
        ev_set = '0; ack_we = 1'b0; mask_we = 1'b0; rx_pop = 1'b0; alloc_req = 1'b0;
        repeat (2) @(posedge clk);
        #3;
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule